// File: doc/BRIEF.md
# Nibble Phase Bridge with Parity

This block sits between a narrow parallel transmit bus and a serializer that runs on its own reference clock. On every rising edge of the write clock it captures a 4-bit nibble and a parity bit. It flags any nibble whose five bits hold an odd number of ones. The nibble then passes through an eight-entry dual-clock FIFO. The read side takes one entry on every read-clock edge, so the FIFO only has to absorb the phase difference between the two clocks. The pointers cross the clock boundary as Gray codes through two-flop synchronizers.

When the frequencies drift apart, the FIFO either fills up (overflow) or runs dry (underflow). In either case the read side raises a spill flag and moves its read pointer onto the synchronized write pointer. After synchronizer latency this leaves the FIFO about half full, and no external reset is involved. The write side reports overflow through a toggle handshake. A small separate receive path registers each outgoing nibble on its own clock and appends an even-parity bit.

A parity error drives an active-low flag for two write-clock cycles. A further error during that window restarts the window.

Top module: `nib_phase_bridge`

## Requirements
- R1: Nibbles captured on rising edges of `wr_clk` leave on `rd_nib` in the order they were written. Between spill episodes, each value read is the previous one plus one when the bench writes an incrementing count modulo 16.
- R2: When the two clocks share a frequency with any fixed phase offset, `spill` stays low once the startup realignment has finished (within 60 read cycles of reset).
- R3: A parity error exists when `wr_nib` and `wr_par` together hold an odd number of ones. Take a bad nibble presented before write edge k. `par_ok_n` is low after edges k+1 and k+2, and high again after edge k+3.
- R4: A nibble with even parity over all five bits never drives `par_ok_n` low.
- R5: A further error inside the low window restarts it. `par_ok_n` stays low until two cycles after the last error's pulse start, then returns high.
- R6: When writes outpace reads, `spill` rises (overflow) and the FIFO realigns. The data is in order again once the episode ends.
- R7: When reads outpace writes, `spill` rises (underflow) and the FIFO realigns. The data is in order again once the episode ends.
- R8: Each spill episode holds `spill` high for exactly four read cycles. It is followed by at least one low cycle.
- R9: On each `rx_clk` edge, `rx_nib_o` takes `rx_nib_i`. `rx_par_o` is set so that the five output bits hold an even number of ones.
- R10: While reset is asserted, `par_ok_n` is 1 and `spill`, `rd_nib`, `rx_nib_o` and `rx_par_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write (capture) clock |
| wr_rst_n | input | 1 | Active-low asynchronous reset, write domain |
| wr_nib | input | 4 | Transmit nibble |
| wr_par | input | 1 | Parity bit accompanying `wr_nib` |
| par_ok_n | output | 1 | Active-low parity error pulse |
| rd_clk | input | 1 | Reference (read) clock |
| rd_rst_n | input | 1 | Active-low asynchronous reset, read domain |
| rd_nib | output | 4 | Nibble toward the serializer |
| spill | output | 1 | High during a slip realignment |
| rx_clk | input | 1 | Receive clock |
| rx_rst_n | input | 1 | Active-low asynchronous reset, receive domain |
| rx_nib_i | input | 4 | Receive nibble in |
| rx_nib_o | output | 4 | Registered receive nibble |
| rx_par_o | output | 1 | Even parity of `rx_nib_o` |

## Verification
A pointer that is wrong or badly synchronized shows on `rd_nib` within a few read cycles, as a break in an incrementing write stream. A slip detector that is too eager shows as `spill` pulses while the two clocks run at the same frequency. A hold counter that is off shows as a spill episode that is not four cycles long. A faulty parity counter shows in the exact sample where `par_ok_n` should rise or fall, one to four write edges after the nibble. The bench checks all 32 nibble and parity combinations and all eight three-nibble error patterns.

// File: rtl/nib_phase_bridge.sv
module nib_phase_bridge #(
  parameter int DW   = 4,
  parameter int AW   = 3,
  parameter int SYNC = 2
) (
  input  logic          wr_clk,
  input  logic          wr_rst_n,
  input  logic [DW-1:0] wr_nib,
  input  logic          wr_par,
  output logic          par_ok_n,
  input  logic          rd_clk,
  input  logic          rd_rst_n,
  output logic [DW-1:0] rd_nib,
  output logic          spill,
  input  logic          rx_clk,
  input  logic          rx_rst_n,
  input  logic [DW-1:0] rx_nib_i,
  output logic [DW-1:0] rx_nib_o,
  output logic          rx_par_o
);

  localparam int DEPTH = 1 << AW;
  localparam int PW    = AW + 1;
  localparam int HOLD  = SYNC + 2;
  localparam int HW    = $clog2(HOLD + 1);

  function automatic logic [PW-1:0] b2g(input logic [PW-1:0] b);
    return (b >> 1) ^ b;
  endfunction

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [DW-1:0] mem [DEPTH];

  // write domain
  logic [DW-1:0] cap_nib;
  logic          cap_par;
  logic [1:0]    perr_cnt;
  logic [PW-1:0] wptr, wgray;
  logic [PW-1:0] rg_s [SYNC];
  logic [SYNC-1:0] ack_sh;
  logic          req;

  // read domain
  logic [PW-1:0] rptr, rgray;
  logic [PW-1:0] wg_s [SYNC];
  logic [SYNC-1:0] req_sh;
  logic          ack;
  logic [HW-1:0] hold;

  wire           cap_bad = ^{cap_nib, cap_par};
  wire [PW-1:0]  wocc    = wptr - g2b(rg_s[SYNC-1]);
  wire           pending = req ^ ack_sh[SYNC-1];

  assign par_ok_n = (perr_cnt == 2'd0);

  always_ff @(posedge wr_clk or negedge wr_rst_n) begin
    if (!wr_rst_n) begin
      cap_nib  <= '0;
      cap_par  <= 1'b0;
      perr_cnt <= 2'd0;
      wptr     <= '0;
      wgray    <= '0;
      req      <= 1'b0;
      ack_sh   <= '0;
      for (int i = 0; i < SYNC; i++) rg_s[i] <= '0;
    end else begin
      cap_nib <= wr_nib;
      cap_par <= wr_par;
      if (cap_bad)
        perr_cnt <= 2'd2;
      else if (perr_cnt != 2'd0)
        perr_cnt <= perr_cnt - 2'd1;
      wptr  <= wptr + 1'b1;
      wgray <= b2g(wptr + 1'b1);
      if (wocc[AW] && !pending) req <= ~req;
      rg_s[0] <= rgray;
      for (int i = 1; i < SYNC; i++) rg_s[i] <= rg_s[i-1];
      ack_sh <= {ack_sh[SYNC-2:0], ack};
    end
  end

  always_ff @(posedge wr_clk) mem[wptr[AW-1:0]] <= cap_nib;

  wire [PW-1:0] wsync_b = g2b(wg_s[SYNC-1]);
  wire [PW-1:0] rocc    = wsync_b - rptr;
  wire          busy    = (hold != '0);
  wire          req_s   = req_sh[SYNC-1];
  wire          slip    = !busy && ((rocc == '0) || rocc[AW] || (req_s != ack));
  wire [PW-1:0] rptr_nx = slip ? wsync_b : rptr + 1'b1;

  always_ff @(posedge rd_clk or negedge rd_rst_n) begin
    if (!rd_rst_n) begin
      rptr   <= '0;
      rgray  <= '0;
      req_sh <= '0;
      ack    <= 1'b0;
      hold   <= '0;
      spill  <= 1'b0;
      rd_nib <= '0;
      for (int i = 0; i < SYNC; i++) wg_s[i] <= '0;
    end else begin
      wg_s[0] <= wgray;
      for (int i = 1; i < SYNC; i++) wg_s[i] <= wg_s[i-1];
      req_sh <= {req_sh[SYNC-2:0], req};
      rptr   <= rptr_nx;
      rgray  <= b2g(rptr_nx);
      if (slip) begin
        spill <= 1'b1;
        hold  <= HW'(HOLD);
      end else begin
        rd_nib <= mem[rptr[AW-1:0]];
        if (busy) begin
          hold <= hold - 1'b1;
          if (hold == HW'(1)) begin
            spill <= 1'b0;
            ack   <= req_s;
          end
        end
      end
    end
  end

  always_ff @(posedge rx_clk or negedge rx_rst_n) begin
    if (!rx_rst_n) begin
      rx_nib_o <= '0;
      rx_par_o <= 1'b0;
    end else begin
      rx_nib_o <= rx_nib_i;
      rx_par_o <= ^rx_nib_i;
    end
  end

endmodule

// File: rtl/nib_phase_bridge_chk.sv
module nib_phase_bridge_chk #(
  parameter int DW = 4,
  parameter int PW = 4
) (
  input logic          wr_clk,
  input logic          wr_rst_n,
  input logic          rd_clk,
  input logic          rd_rst_n,
  input logic          rx_clk,
  input logic          rx_rst_n,
  input logic          par_ok_n,
  input logic [DW-1:0] cap_nib,
  input logic          cap_par,
  input logic [PW-1:0] wgray,
  input logic          spill,
  input logic [DW-1:0] rx_nib_i,
  input logic [DW-1:0] rx_nib_o,
  input logic          rx_par_o
);

  // R3
  par_pulse_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (^{cap_nib, cap_par}) |=> !par_ok_n ##1 !par_ok_n);

  // R4
  par_quiet_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    (!(^{cap_nib, cap_par}) && !$past(^{cap_nib, cap_par})) |=> par_ok_n);

  // R1
  gray_step_chk: assert property (@(posedge wr_clk) disable iff (!wr_rst_n)
    $onehot0(wgray ^ $past(wgray)));

  // R8
  spill_len_chk: assert property (@(posedge rd_clk) disable iff (!rd_rst_n)
    $rose(spill) |=> spill ##1 spill ##1 spill ##1 !spill);

  // R9
  rx_par_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    !(rx_par_o ^ (^rx_nib_o)));

  // R9
  rx_pipe_chk: assert property (@(posedge rx_clk) disable iff (!rx_rst_n)
    $past(rx_rst_n) |-> (rx_nib_o == $past(rx_nib_i)));

endmodule

bind nib_phase_bridge nib_phase_bridge_chk #(.DW(DW), .PW(AW + 1)) u_chk (.*);

// File: tb/nib_phase_bridge_test.sv
`timescale 1ns/1ps
module nib_phase_bridge_test;

  logic       wr_clk = 1'b0, rd_clk = 1'b0, rx_clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] wr_nib = '0;
  logic       wr_par = 1'b0;
  logic [3:0] rx_nib_i = '0;
  logic       par_ok_n, spill, rx_par_o;
  logic [3:0] rd_nib, rx_nib_o;

  realtime wr_half = 10.0;
  int  checks = 0, fails = 0;
  bit  done = 1'b0, stop_wr = 1'b0;
  logic [3:0] wseq = '0;

  always #10 rd_clk = ~rd_clk;
  always #10 rx_clk = ~rx_clk;
  initial begin
    #7;
    forever #(wr_half) wr_clk = ~wr_clk;
  end

  nib_phase_bridge uut (
    .wr_clk(wr_clk), .wr_rst_n(rst_n), .wr_nib(wr_nib), .wr_par(wr_par), .par_ok_n(par_ok_n),
    .rd_clk(rd_clk), .rd_rst_n(rst_n), .rd_nib(rd_nib), .spill(spill),
    .rx_clk(rx_clk), .rx_rst_n(rst_n), .rx_nib_i(rx_nib_i), .rx_nib_o(rx_nib_o), .rx_par_o(rx_par_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic writer();
    while (!stop_wr) begin
      @(negedge wr_clk);
      wr_nib = wseq;
      wr_par = ^wseq;
      wseq   = wseq + 4'd1;
    end
  endtask

  task automatic watch(input int n, input string req, input bit expect_quiet);
    logic [3:0] prev = rd_nib;
    bit prev_sp = 1'b1;
    int run = 0, rises = 0;
    for (int c = 0; c < n; c++) begin
      @(negedge rd_clk);
      if (spill) run++;
      else begin
        if (run > 0) chk(run == 4, "R8", run, 4);
        run = 0;
      end
      if (spill && !prev_sp && c > 0) rises++;
      if (!spill && !prev_sp) chk(rd_nib == prev + 4'd1, req, rd_nib, prev + 4'd1);
      prev    = rd_nib;
      prev_sp = spill;
    end
    if (expect_quiet) chk(rises == 0, "R2", rises, 0);
    else              chk(rises > 0, req, rises, 1);
  endtask

  task automatic par_pattern(input logic [2:0] pat);
    string tag;
    tag = ($countones(pat) >= 2) ? "R5" : (pat != 0 ? "R3" : "R4");
    for (int k = 0; k < 8; k++) begin
      @(negedge wr_clk);
      if (k >= 1) begin
        bit low = 1'b0;
        for (int j = 0; j < 3; j++)
          if (pat[j] && k - j >= 2 && k - j <= 3) low = 1'b1;
        chk(par_ok_n == !low, tag, par_ok_n, !low);
      end
      wr_nib = 4'd5;
      wr_par = (k < 3) ? pat[k] : 1'b0;
    end
  endtask

  initial begin
    repeat (5) @(negedge rd_clk);
    chk(par_ok_n == 1'b1, "R10", par_ok_n, 1);
    chk(spill == 1'b0, "R10", spill, 0);
    chk(rd_nib == 4'd0, "R10", rd_nib, 0);
    chk(rx_nib_o == 4'd0 && rx_par_o == 1'b0, "R10", {rx_nib_o, rx_par_o}, 0);
    rst_n = 1'b1;

    fork writer(); join_none
    repeat (60) @(negedge rd_clk);
    watch(400, "R1", 1'b1);
    wr_half = 9.0;
    repeat (10) @(negedge rd_clk);
    watch(800, "R6", 1'b0);
    wr_half = 11.0;
    repeat (10) @(negedge rd_clk);
    watch(800, "R7", 1'b0);
    wr_half = 10.0;
    repeat (80) @(negedge rd_clk);
    watch(300, "R1", 1'b1);
    stop_wr = 1'b1;
    repeat (4) @(negedge wr_clk);

    wr_nib = 4'd0; wr_par = 1'b0;
    repeat (4) @(negedge wr_clk);
    for (int d = 0; d < 16; d++) begin
      for (int p = 0; p < 2; p++) begin
        bit bad;
        bad = ($countones(d) + p) % 2 == 1;
        @(negedge wr_clk);
        wr_nib = 4'(d); wr_par = 1'(p);
        @(negedge wr_clk);
        chk(par_ok_n == 1'b1, bad ? "R3" : "R4", par_ok_n, 1);
        wr_nib = 4'd0; wr_par = 1'b0;
        @(negedge wr_clk);
        chk(par_ok_n == !bad, bad ? "R3" : "R4", par_ok_n, !bad);
        @(negedge wr_clk);
        chk(par_ok_n == !bad, bad ? "R3" : "R4", par_ok_n, !bad);
        @(negedge wr_clk);
        chk(par_ok_n == 1'b1, bad ? "R3" : "R4", par_ok_n, 1);
      end
    end
    for (int pat = 0; pat < 8; pat++) begin
      par_pattern(3'(pat));
      repeat (4) @(negedge wr_clk);
    end

    for (int d = 0; d < 16; d++) begin
      @(negedge rx_clk);
      rx_nib_i = 4'(d);
      @(negedge rx_clk);
      chk(rx_nib_o == 4'(d), "R9", rx_nib_o, d);
      chk(rx_par_o == 1'($countones(d) % 2), "R9", rx_par_o, $countones(d) % 2);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R1: watchdog expired, got 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule